// File: doc/BRIEF.md
# Digit-Decomposed Signed Multiplier with Thermometer Recombination

This block multiplies two L-bit two's complement operands by cutting each one into small signed digits of N bits. It feeds every digit pair through a small product cell and reassembles the full 2L-bit signed product. Each cell stands in for a bank of level comparators. It does not return its product in binary. It returns a thermometer code whose length is one less than the number of distinct values a product of two N-bit signed digits can take. The recombination logic counts the ones in the code and looks the count up in a table of those reachable values, sorted in ascending order. It then shifts the decoded value by the combined weight of the two digits and adds it into a 2L-bit accumulator.

The recoding walks each operand from its least significant end. It adds the incoming carry to each N-bit chunk. A chunk sum at or above 2^(N-1) produces a negative digit and a carry of one. One extra top digit, equal to the final carry minus the operand's sign bit, absorbs the sign. Every operand therefore becomes L/N+1 digits, each within the signed N-bit range. The block handles one digit pair per clock. A start strobe launches a multiplication, and a one-cycle done pulse marks the result. L must be a multiple of N, and N lies between 2 and 4.

Top module: `smr_mult`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, product is 0, done is 0 and code_err is 0.
- R2: After each accepted start, product equals the exact signed product of op_a and op_b read as L-bit two's complement values, as a 2L-bit two's complement value. This holds for the most negative, most positive, zero and minus-one operands.
- R3: For a digit pair whose product holds position k (counting from 0) in the ascending list of distinct products of two N-bit signed digits, a cell's thermometer code has bits 0 to k-1 set and all other bits clear. The code is one bit shorter than that list. For N=2 the list is -2, -1, 0, 1, 2, 4, and the code is 5 bits wide.
- R4: The decoder maps a code made of k ones packed from bit 0 upward to entry k of the same ascending list, with its bad output low. Any other pattern drives bad high.
- R5: done rises exactly (L/N+1)^2 + 2 rising edges after start is accepted, counting the edge that samples start as the first.
- R6: done stays high for exactly one cycle, once for each accepted start.
- R7: A start that arrives while a multiplication is in progress is ignored. It changes neither the result, the done timing nor the number of done pulses.
- R8: product holds its value between done pulses, even when the operands change while start is low.
- R9: code_err is sticky. It is set whenever a decoded code during a run is not a valid thermometer code, and only reset clears it. With exact cells it stays 0 through every multiplication.
- R10: The same design gives exact results for 8x8 with N=2 and N=4, for 12x12 with N=3, and for 16x16 with N=2 and N=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a multiplication when the block is idle |
| op_a | input | L | First operand, two's complement |
| op_b | input | L | Second operand, two's complement |
| product | output | 2L | Signed result, updated together with done |
| done | output | 1 | One-cycle pulse marking a new result |
| code_err | output | 1 | Sticky flag for an invalid thermometer code |

## Verification
On every clock, the assertions check that no invalid thermometer code reaches the accumulator during a run and that the error flag stays low. They also check that done never lasts two cycles, that a busy block never drops back to idle on a new start, and that product moves only on the cycle the result is published. Only the bench scenarios can show arithmetic correctness across operand values and digit sizes. The same holds for the exact done latency for each digit count and for the value-to-code mapping of the cell and decoder. Proving that an ignored start truly leaves the result untouched also needs a bench scenario.

// File: rtl/smr_pkg.sv
package smr_pkg;

    // Control phases of the serial recombiner
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_PUB  = 2'd2
    } phase_e;

    // One product level; wide enough for N up to 4 (range -56..64)
    typedef logic signed [7:0] lvl_t;
    // Table of ascending reachable levels, at most 64 entries
    typedef lvl_t [63:0] lvl_tbl_t;

    // True when v is the product of two signed n-bit digits
    function automatic bit reachable(int n, int v);
        int  h;
        bit  hit;
        h   = 1 << (n - 1);
        hit = 1'b0;
        for (int x = -h; x < h; x++) begin
            if (x == 0) begin
                if (v == 0) hit = 1'b1;
            end else if ((v % x) == 0) begin
                if ((v / x) >= -h && (v / x) < h) hit = 1'b1;
            end
        end
        return hit;
    endfunction

    // Number of distinct products of two signed n-bit digits
    function automatic int level_count(int n);
        int h;
        int cnt;
        h   = 1 << (n - 1);
        cnt = 0;
        for (int v = -h * (h - 1); v <= h * h; v++)
            if (reachable(n, v)) cnt++;
        return cnt;
    endfunction

    // Ascending list of the distinct products
    function automatic lvl_tbl_t level_table(int n);
        lvl_tbl_t t;
        int       k;
        int       h;
        t = '0;
        k = 0;
        h = 1 << (n - 1);
        for (int v = -h * (h - 1); v <= h * h; v++) begin
            if (reachable(n, v)) begin
                t[k] = lvl_t'(v);
                k++;
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/smr_recode.sv
module smr_recode #(
    parameter int L = 16,
    parameter int N = 2
) (
    input  logic [L-1:0]           operand,
    output logic [(L/N+1)*N-1:0]   digits
);
    localparam int CHUNKS = L / N;
    localparam int HALF   = 1 << (N - 1);

    always_comb begin
        logic [N:0] sum;
        logic       cy;
        cy     = 1'b0;
        digits = '0;
        for (int i = 0; i < CHUNKS; i++) begin
            sum = {1'b0, operand[i*N +: N]} + {{N{1'b0}}, cy};
            // low N bits equal the sum minus 2^N when the digit goes negative
            digits[i*N +: N] = sum[N-1:0];
            cy = (sum >= (N+1)'(HALF));
        end
        // top digit: final carry minus the sign weight, always in {-1,0,1}
        digits[CHUNKS*N +: N] = N'(cy) - N'(operand[L-1]);
    end

endmodule

// File: rtl/smr_cell.sv
module smr_cell
    import smr_pkg::*;
#(
    parameter int N = 2
) (
    input  logic signed [N-1:0]             dig_a,
    input  logic signed [N-1:0]             dig_b,
    output logic [level_count(N)-2:0]       therm
);
    localparam int       LEVELS = level_count(N);
    localparam int       TW     = LEVELS - 1;
    localparam lvl_tbl_t TBL    = level_table(N);

    logic signed [2*N-1:0] prod;
    lvl_t                  prod_x;

    assign prod   = (2*N)'(dig_a) * (2*N)'(dig_b);
    assign prod_x = lvl_t'(prod);

    // One comparator per boundary between adjacent levels
    for (genvar j = 0; j < TW; j++) begin : g_cmp
        assign therm[j] = (prod_x > TBL[j]);
    end

endmodule

// File: rtl/smr_decode.sv
module smr_decode
    import smr_pkg::*;
#(
    parameter int N = 2
) (
    input  logic [level_count(N)-2:0]   therm,
    output logic signed [2*N-1:0]       level,
    output logic                        bad
);
    localparam int       TW  = level_count(N) - 1;
    localparam lvl_tbl_t TBL = level_table(N);

    logic [5:0] ones;

    always_comb begin
        ones = '0;
        for (int j = 0; j < TW; j++)
            ones = ones + 6'(therm[j]);
    end

    assign level = (2*N)'(TBL[ones]);
    // a valid code is a solid run of ones starting at bit 0
    assign bad   = |(therm & (therm + TW'(1)));

endmodule

// File: rtl/smr_mult.sv
module smr_mult
    import smr_pkg::*;
#(
    parameter int L = 16,
    parameter int N = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [L-1:0]         op_a,
    input  logic [L-1:0]         op_b,
    output logic signed [2*L-1:0] product,
    output logic                 done,
    output logic                 code_err
);
    localparam int D  = L / N + 1;
    localparam int IW = $clog2(D);
    localparam int AW = 2 * L;
    localparam int TW = level_count(N) - 1;

    typedef struct packed {
        logic [IW-1:0] row;
        logic [IW-1:0] col;
    } pair_t;

    phase_e               phase_q;
    pair_t                pair_q;
    logic [D*N-1:0]       dig_a_w, dig_b_w;
    logic [D*N-1:0]       dig_a_q, dig_b_q;
    logic signed [N-1:0]  cur_a, cur_b;
    logic [TW-1:0]        therm;
    logic signed [2*N-1:0] level;
    logic                 bad;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] term;
    logic                 last_pair;

    smr_recode #(.L(L), .N(N)) u_rec_a (.operand(op_a), .digits(dig_a_w));
    smr_recode #(.L(L), .N(N)) u_rec_b (.operand(op_b), .digits(dig_b_w));

    assign cur_a = dig_a_q[int'(pair_q.row)*N +: N];
    assign cur_b = dig_b_q[int'(pair_q.col)*N +: N];

    smr_cell   #(.N(N)) u_cell (.dig_a(cur_a), .dig_b(cur_b), .therm(therm));
    smr_decode #(.N(N)) u_dec  (.therm(therm), .level(level), .bad(bad));

    // weight of the pair is 2^(N*(row+col)); bits past AW wrap away modulo 2^AW
    always_comb begin
        int shamt;
        shamt = N * (int'(pair_q.row) + int'(pair_q.col));
        term  = AW'(level) << shamt;
    end

    assign last_pair = (pair_q.row == IW'(D - 1)) && (pair_q.col == IW'(D - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            pair_q   <= '0;
            dig_a_q  <= '0;
            dig_b_q  <= '0;
            acc_q    <= '0;
            product  <= '0;
            done     <= 1'b0;
            code_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        dig_a_q <= dig_a_w;
                        dig_b_q <= dig_b_w;
                        pair_q  <= '0;
                        acc_q   <= '0;
                        phase_q <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    acc_q <= acc_q + term;
                    if (bad) code_err <= 1'b1;
                    if (last_pair) begin
                        phase_q <= PH_PUB;
                    end else if (pair_q.col == IW'(D - 1)) begin
                        pair_q.col <= '0;
                        pair_q.row <= pair_q.row + 1'b1;
                    end else begin
                        pair_q.col <= pair_q.col + 1'b1;
                    end
                end
                PH_PUB: begin
                    product <= acc_q;
                    done    <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R3 / R4: the cell output reaching the accumulator is always a clean code
    a_r3_code_shape: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN) |-> !bad);

    // R9: exact cells never raise the sticky flag
    a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
        !code_err);

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: a running multiplication is never abandoned
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN) |=> (phase_q == PH_RUN || phase_q == PH_PUB));

    // R8: product moves only on the publishing cycle
    a_r8_product_hold: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_PUB) |=> $stable(product));

endmodule

// File: tb/tb_smr_mult.sv
module tb_smr_mult;
    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [15:0] a16, b16;
    logic [7:0]  a8, b8;
    logic [11:0] a12, b12;

    always #5 clk = ~clk;

    logic signed [31:0] p0, p4;
    logic signed [15:0] p1, p2;
    logic signed [23:0] p3;
    logic d0, d1, d2, d3, d4;
    logic e0, e1, e2, e3, e4;

    smr_mult #(.L(16), .N(2)) dut   (.clk(clk), .rst(rst), .start(start), .op_a(a16), .op_b(b16),
                                     .product(p0), .done(d0), .code_err(e0));
    smr_mult #(.L(8),  .N(2)) u8n2  (.clk(clk), .rst(rst), .start(start), .op_a(a8),  .op_b(b8),
                                     .product(p1), .done(d1), .code_err(e1));
    smr_mult #(.L(8),  .N(4)) u8n4  (.clk(clk), .rst(rst), .start(start), .op_a(a8),  .op_b(b8),
                                     .product(p2), .done(d2), .code_err(e2));
    smr_mult #(.L(12), .N(3)) u12n3 (.clk(clk), .rst(rst), .start(start), .op_a(a12), .op_b(b12),
                                     .product(p3), .done(d3), .code_err(e3));
    smr_mult #(.L(16), .N(4)) u16n4 (.clk(clk), .rst(rst), .start(start), .op_a(a16), .op_b(b16),
                                     .product(p4), .done(d4), .code_err(e4));

    // standalone N=2 cell and decoder for code checks
    logic signed [1:0] ca, cb;
    logic [4:0] cell_code;
    logic [4:0] dec_in;
    logic signed [3:0] dec_lvl;
    logic dec_bad;
    smr_cell   #(.N(2)) cell_u (.dig_a(ca), .dig_b(cb), .therm(cell_code));
    smr_decode #(.N(2)) dec_u  (.therm(dec_in), .level(dec_lvl), .bad(dec_bad));

    longint got [5];
    logic   dn  [5];
    logic   er  [5];
    always_comb begin
        got[0] = longint'(p0); got[1] = longint'(p1); got[2] = longint'(p2);
        got[3] = longint'(p3); got[4] = longint'(p4);
        dn[0] = d0; dn[1] = d1; dn[2] = d2; dn[3] = d3; dn[4] = d4;
        er[0] = e0; er[1] = e1; er[2] = e2; er[3] = e3; er[4] = e4;
    end

    int WID [5] = '{16, 8, 8, 12, 16};
    int DIG [5] = '{2, 2, 4, 3, 4};
    int checks = 0;
    int fails  = 0;
    longint last_exp [5];
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 195000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic longint sx(longint v, int w);
        return (v <<< (64 - w)) >>> (64 - w);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_ops(input longint a, input longint b);
        a16 = a[15:0]; b16 = b[15:0];
        a8  = a[7:0];  b8  = b[7:0];
        a12 = a[11:0]; b12 = b[11:0];
    endtask

    // one multiplication on all instances; poke issues a second start mid-run
    task automatic run_op(input longint a, input longint b, input bit poke);
        int first [5];
        int cnt   [5];
        for (int i = 0; i < 5; i++) begin first[i] = 0; cnt[i] = 0; end
        @(negedge clk);
        set_ops(a, b);
        start = 1'b1;
        for (int c = 1; c <= 90; c++) begin
            @(posedge clk); #1;
            if (c == 1) start = 1'b0;
            if (poke && c == 5) begin set_ops(~a, b + 3); start = 1'b1; end
            if (poke && c == 6) start = 1'b0;
            for (int i = 0; i < 5; i++)
                if (dn[i]) begin
                    cnt[i]++;
                    if (first[i] == 0) first[i] = c;
                end
        end
        for (int i = 0; i < 5; i++) begin
            longint ex;
            int lat;
            ex  = sx(a, WID[i]) * sx(b, WID[i]);
            lat = (WID[i] / DIG[i] + 1) * (WID[i] / DIG[i] + 1) + 2;
            last_exp[i] = ex;
            check(got[i] == ex, (i == 0) ? "R2" : "R10", "product", got[i], ex);
            check(first[i] == lat, poke ? "R7" : "R5", "done latency", first[i], lat);
            check(cnt[i] == 1, poke ? "R7" : "R6", "done pulses", cnt[i], 1);
            check(er[i] == 1'b0, "R9", "code_err", er[i], 0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; set_ops(0, 0);
        repeat (5) @(posedge clk);
        #1;
        for (int i = 0; i < 5; i++) begin
            check(got[i] == 0, "R1", "product in reset", got[i], 0);
            check(dn[i] == 0, "R1", "done in reset", dn[i], 0);
        end
        rst = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < 5; i++) begin
            check(got[i] == 0, "R1", "product after reset", got[i], 0);
            check(er[i] == 0, "R1", "code_err after reset", er[i], 0);
        end
    endtask

    task automatic t_corners();
        longint cv [10] = '{-32768, 32767, 0, -1, 1, -128, 127, -2048, 2047, 23130};
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                run_op(cv[i], cv[j], 1'b0);
    endtask

    task automatic t_grid8();
        for (int a = -128; a < 128; a += 17)
            for (int b = -128; b < 128; b += 19)
                run_op(longint'(a), longint'(b), 1'b0);
        run_op(127, -128, 1'b0);
        run_op(-128, -128, 1'b0);
    endtask

    task automatic t_random(input int n);
        for (int k = 0; k < n; k++)
            run_op(longint'($urandom), longint'($urandom), 1'b0);
    endtask

    task automatic t_busy_start();
        run_op(-12345, 321, 1'b1);
        run_op(32767, -32768, 1'b1);
    endtask

    task automatic t_hold();
        @(negedge clk);
        set_ops(longint'($urandom), longint'($urandom));
        start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(posedge clk); #1;
            for (int i = 0; i < 5; i++)
                if (dn[i]) check(1'b0, "R8", "spurious done", 1, 0);
        end
        for (int i = 0; i < 5; i++)
            check(got[i] == last_exp[i], "R8", "held product", got[i], last_exp[i]);
    endtask

    task automatic t_cell_codes();
        int lv [6] = '{-2, -1, 0, 1, 2, 4};
        for (int x = -2; x < 2; x++)
            for (int y = -2; y < 2; y++) begin
                int k;
                logic [4:0] exp;
                ca = 2'(x); cb = 2'(y);
                #1;
                k = 0;
                for (int m = 0; m < 6; m++) if (lv[m] == x * y) k = m;
                exp = 5'((1 << k) - 1);
                check(cell_code == exp, "R3", "cell code", longint'(cell_code), longint'(exp));
            end
    endtask

    task automatic t_decode_patterns();
        int lv [6] = '{-2, -1, 0, 1, 2, 4};
        for (int p = 0; p < 32; p++) begin
            bit valid;
            int k;
            dec_in = 5'(p);
            #1;
            valid = (p == 0 || p == 1 || p == 3 || p == 7 || p == 15 || p == 31);
            check(dec_bad == !valid, "R4", "bad flag", dec_bad, !valid);
            if (valid) begin
                k = $countones(p);
                check(longint'(dec_lvl) == lv[k], "R4", "decoded level", dec_lvl, lv[k]);
            end
        end
    endtask

    initial begin
        ca = '0; cb = '0; dec_in = '0;
        t_reset();
        t_cell_codes();
        t_decode_patterns();
        t_corners();
        t_grid8();
        t_busy_start();
        t_hold();
        t_random(300);
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule